// File: doc/BRIEF.md
# Four-level interrupt priority resolver

This block takes six interrupt request lines and picks the one the core should service next. Each source gets a two-bit level. One bit comes from a low-priority mask and one from a high-priority mask. Level 3 is the most urgent and level 0 the least. Between levels, the higher level always wins. Within a level, a fixed scan order picks the winner.

Requests are captured once per machine cycle, on a `cyc_tick` strobe. A vector is granted only on such a boundary. A grant raises a one-cycle strobe with the source index and its level, and marks that level as in service. A return-from-interrupt pulse releases the highest level in service. A pending request may interrupt a running handler only when its level is above every level in service.

The core fetches the vector and stacks the return address; neither is part of this block. The logic that sets and clears each source flag is also outside the block. The serial source's line is the OR of its receive and transmit flags, formed outside the block.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, `in_svc`, `vec_stb` and `core_req` are all 0.
- R2: `src_req` is captured only at a clock edge where `cyc_tick` is 1. A change of `src_req` between ticks has no effect on `core_req`.
- R3: Source i has level {`pri_hi[i]`,`pri_lo[i]`}, with 3 the highest. Among pending sources, one with a higher level wins.
- R4: Among pending sources of the same level, the lowest bit index wins. The bit order is: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R5: A grant is made only at a clock edge where `cyc_tick` is 1, using the requests captured at an earlier tick. `vec_stb` is 1 for exactly the one cycle after that edge, with `vec_idx` and `vec_lvl` naming the winner.
- R6: While `glb_en` is 0, no grant is made and `core_req` is 0.
- R7: A source whose `src_en` bit is 0 is never granted and does not raise `core_req`.
- R8: A grant is made only if the winner's level is strictly above every level set in `in_svc`. A request at the same or a lower level waits.
- R9: A grant sets `in_svc[vec_lvl]`.
- R10: A `reti` pulse clears the highest set bit of `in_svc` and leaves the lower bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | Machine-cycle boundary strobe |
| src_req | input | NSRC | Raw source request flags |
| src_en | input | NSRC | Per-source enable |
| pri_lo | input | NSRC | Low bit of each source's level |
| pri_hi | input | NSRC | High bit of each source's level |
| glb_en | input | 1 | Global interrupt enable |
| reti | input | 1 | Return-from-interrupt pulse |
| core_req | output | 1 | An eligible request is pending |
| vec_stb | output | 1 | One-cycle grant strobe |
| vec_idx | output | $clog2(NSRC) | Granted source index |
| vec_lvl | output | 2 | Granted level |
| in_svc | output | 4 | Per-level in-service flags |

## Verification
Assertions check on every cycle that:
- grants happen only on a tick, with the global enable set and the source enabled;
- a granted level lies above everything previously in service, and its flag is set;
- a return without a concurrent grant drops exactly one in-service flag.

Only the bench scenarios can show which source wins:
- across all request patterns under several level maps and enable masks, which is the tie-break order and the level comparison;
- that a changed request is ignored between ticks;
- that nesting unwinds from the top level down.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int NSRC = 6,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_tick,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] pri_lo,
  input  logic [NSRC-1:0] pri_hi,
  input  logic            glb_en,
  input  logic            reti,
  output logic            core_req,
  output logic            vec_stb,
  output logic [IW-1:0]   vec_idx,
  output logic [1:0]      vec_lvl,
  output logic [3:0]      in_svc
);
  localparam int NLVL = 4;

  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] pend;
  logic            found;
  logic [1:0]      best_lvl;
  logic [IW-1:0]   best_idx;
  logic [1:0]      top_lvl;
  logic            any_svc;
  logic            grant;
  logic [NLVL-1:0] top_mask;
  logic [NLVL-1:0] new_mask;

  assign pend = req_q & src_en;

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && (!found || {pri_hi[i], pri_lo[i]} >= best_lvl)) begin
        found    = 1'b1;
        best_lvl = {pri_hi[i], pri_lo[i]};
        best_idx = IW'(i);
      end
    end
  end

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < NLVL; l++)
      if (in_svc[l]) top_lvl = 2'(l);
  end

  assign any_svc  = |in_svc;
  assign core_req = glb_en && found && (!any_svc || best_lvl > top_lvl);
  assign grant    = cyc_tick && core_req;
  assign top_mask = (reti && any_svc) ? (NLVL'(1) << top_lvl) : '0;
  assign new_mask = grant ? (NLVL'(1) << best_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= '0;
      vec_stb <= 1'b0;
      vec_idx <= '0;
      vec_lvl <= '0;
      in_svc  <= '0;
    end else begin
      if (cyc_tick) req_q <= src_req;
      vec_stb <= grant;
      if (grant) begin
        vec_idx <= best_idx;
        vec_lvl <= best_lvl;
      end
      in_svc <= (in_svc & ~top_mask) | new_mask;
    end
  end

  p_grant_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb |-> $past(cyc_tick));
  p_glb_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb |-> $past(glb_en));
  p_src_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb |-> ((($past(src_en) >> vec_idx) & NSRC'(1)) != '0));
  p_strict_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb |-> (($past(in_svc) >> vec_lvl) == 4'd0));
  p_mark_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb |-> in_svc[vec_lvl]);
  p_release_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reti) && $past(in_svc) != 4'd0 && !vec_stb) |->
      ($countones(in_svc) + 1 == $countones($past(in_svc))));
endmodule

// File: tb/sim_irq_level_arbiter.sv
module sim_irq_level_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic clk = 0, rst_n = 0, cyc_tick = 0, glb_en = 0, reti = 0;
  logic [N-1:0] src_req = '0, src_en = '0, pri_lo = '0, pri_hi = '0;
  logic core_req, vec_stb;
  logic [2:0] vec_idx;
  logic [1:0] vec_lvl;
  logic [3:0] in_svc;
  int total = 0, bad = 0;
  bit done = 0;

  irq_level_arbiter #(.NSRC(N)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    cyc_tick = 1; @(negedge clk); cyc_tick = 0;
  endtask

  task automatic pulse_reti();
    reti = 1; @(negedge clk); reti = 0;
  endtask

  // returns idx*4+lvl of winner, or -1
  function automatic int model(logic [N-1:0] rq, logic [N-1:0] en,
                               logic [N-1:0] lo, logic [N-1:0] hi, logic [3:0] svc);
    int top = -1;
    for (int l = 0; l < 4; l++) if (svc[l]) top = l;
    for (int l = 3; l >= 0; l--)
      for (int i = 0; i < N; i++)
        if (rq[i] && en[i] && (2 * hi[i] + lo[i]) == l)
          return (l > top) ? i * 4 + l : -1;
    return -1;
  endfunction

  task automatic trial(string tag, logic [N-1:0] rq);
    int e = model(rq, src_en, pri_lo, pri_hi, 4'd0);
    src_req = rq; tick();
    chk({tag, " core_req"}, int'(core_req), int'(e >= 0 && glb_en));
    tick();
    chk({tag, " stb"}, int'(vec_stb), int'(e >= 0 && glb_en));
    if (e >= 0 && glb_en) begin
      chk({tag, " idx"}, int'(vec_idx), e / 4);
      chk({tag, " lvl R9"}, int'(vec_lvl), e % 4);
      chk({tag, " in_svc R9"}, int'(in_svc), 1 << (e % 4));
    end
    src_req = '0; tick();
    pulse_reti();
    chk({tag, " release R10"}, int'(in_svc), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in_svc", int'(in_svc), 0);
    chk("R1 vec_stb", int'(vec_stb), 0);
    chk("R1 core_req", int'(core_req), 0);
    rst_n = 1; glb_en = 1; src_en = '1;
    @(negedge clk);

    // R2: request change without tick is ignored
    src_req = 6'b000100; repeat (3) @(negedge clk);
    chk("R2 no tick", int'(core_req), 0);
    tick();
    chk("R2 after tick", int'(core_req), 1);
    // R5: no grant while no tick
    repeat (3) begin
      @(negedge clk);
      chk("R5 no tick grant", int'(vec_stb), 0);
    end
    tick();
    chk("R5 grant", int'(vec_stb), 1);
    @(negedge clk);
    chk("R5 one cycle", int'(vec_stb), 0);
    src_req = '0; tick(); pulse_reti();

    // R3 R4: sweep all request patterns over level maps
    for (int k = 0; k < 8; k++) begin
      pri_lo = N'((k * 13 + 5) % 64);
      pri_hi = N'((k * 29 + 3) % 64);
      if (k == 0) begin pri_lo = '0; pri_hi = '0; end
      for (int r = 0; r < 64; r++) trial("R3 R4 sweep", N'(r));
    end

    // R7: per-source enable masks
    pri_lo = 6'b101010; pri_hi = 6'b110011;
    for (int m = 0; m < 64; m++) begin
      src_en = N'(m);
      trial("R7 mask", 6'b111111);
    end
    src_en = '1;

    // R6: global enable off
    glb_en = 0;
    for (int r = 1; r < 64; r += 7) trial("R6 glb off", N'(r));
    glb_en = 1;

    // R8 R10: nesting
    pri_lo = 6'b000101; pri_hi = 6'b001100; // levels: s0=1 s1=0 s2=3 s3=2 others 0
    src_req = 6'b000001; tick(); tick();
    chk("R8 first lvl", int'(vec_lvl), 1);
    src_req = 6'b010010; tick(); tick();   // lvl0 sources: wait
    chk("R8 lower waits", int'(vec_stb), 0);
    src_req = 6'b000001; tick(); tick();   // same level waits
    chk("R8 same waits", int'(vec_stb), 0);
    src_req = 6'b001000; tick(); tick();   // level 2 preempts
    chk("R8 preempt idx", int'(vec_idx), 3);
    chk("R8 nest svc", int'(in_svc), 4'b0110);
    src_req = '0; tick();
    pulse_reti();
    chk("R10 top first", int'(in_svc), 4'b0010);
    pulse_reti();
    chk("R10 last", int'(in_svc), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule